// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a bank of level-sensitive interrupt request lines and keeps, for every line, an enable flag, a programmable urgency level and a four-state lifecycle: inactive, pending, active, or active-and-pending. On every cycle it picks the most urgent request that is both enabled and pending. If the core's global mask is clear and that request outranks the handler now running, the block offers it to the core as an interrupt number with a valid strobe.

Software reaches the block through a single-cycle register bus. Enable and pending bits each have a write-one-to-set address and a separate write-one-to-clear address. Active bits are read-only. Urgency levels are packed four lines to a word. The core reports three things: when it takes the offered interrupt (acknowledge), when a handler returns (completion, with the interrupt number), and its current execution priority. Nesting happens naturally: a more urgent line can be taken while an earlier handler is still active.

Top module: `pic_top`

## Requirements
- R1: After reset, every line is inactive, all enable bits and urgency levels are zero, and `irq_valid` is low.
- R2: The bus address is split into a region field in `bus_addr[7:5]` and a word index in `bus_addr[4:0]`. Line n sits at bit n%32 of word n/32. Writing 1 in region 0 enables a line and writing 1 in region 1 disables it. Written zeros change nothing. A read of either region returns the enable bits.
- R3: Region 2 (set) and region 3 (clear) act in the same way on pending bits, and a read of either returns the pending bits.
- R4: A rising edge on a request line sets its pending bit whether or not the line is enabled. A line held high after acknowledge does not become pending again.
- R5: In region 5, byte j of word k holds the urgency of line 4k+j. Only the upper 4 bits are kept, and the lower 4 bits read back as zero.
- R6: Among the lines that are enabled and pending, the one with the numerically lowest urgency is offered. On a tie, the lower line number wins.
- R7: A request is offered only if its urgency is strictly below `core_prio`. A value of 16 on `core_prio` means no handler is running.
- R8: While `core_mask` is 1, nothing is offered, but pending bits stay recorded. The request is offered once the mask clears.
- R9: An acknowledge while `irq_valid` is high moves the offered line from pending to active. Region 4 reads the active bits.
- R10: A rising edge on a line whose handler is active makes it active-and-pending. Completion then returns it to pending, and it is offered again.
- R11: Completion clears the active bit of the named line. Several lines can be active at once when handlers nest.
- R12: If an acknowledge and a rising edge on the same line arrive in the same cycle, the line ends up active-and-pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 96 | Level request lines |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 8 | Region and word index |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data (combinational) |
| core_mask | input | 1 | Global mask for all lines |
| core_prio | input | 5 | Current execution priority, 16 = none |
| core_ack | input | 1 | Core takes the offered interrupt |
| core_done | input | 1 | A handler returns |
| core_done_id | input | 7 | Line whose handler returns |
| irq_valid | output | 1 | A request is offered |
| irq_id | output | 7 | Offered line number |
| irq_prio | output | 4 | Urgency of the offered line |

## Verification
The sharpest collision is between acknowledge and a fresh rising edge on the same line in the same cycle. The bench drops the line for one cycle, then drives `core_ack` and the new rising edge on the same falling clock edge. It judges the result by reading the active and pending words over the bus, both of which must show the line set. A second collision pairs completion with a line that was re-requested while its handler ran. There, the pending read and the renewed `irq_valid` must both show the line again.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        LS_IDLE = 2'b00,
        LS_PEND = 2'b01,
        LS_ACT  = 2'b10,
        LS_BOTH = 2'b11
    } line_state_t;

    localparam logic [2:0] RG_EN_SET   = 3'd0;
    localparam logic [2:0] RG_EN_CLR   = 3'd1;
    localparam logic [2:0] RG_PEND_SET = 3'd2;
    localparam logic [2:0] RG_PEND_CLR = 3'd3;
    localparam logic [2:0] RG_ACTIVE   = 3'd4;
    localparam logic [2:0] RG_PRIO     = 3'd5;

endpackage

// File: rtl/pic_line.sv
module pic_line
    import pic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic take,
    input  logic finish,
    output logic pend_o,
    output logic act_o
);
    line_state_t state_q, state_d;
    logic        raise;

    assign raise = set_req && !clr_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_IDLE: if (raise) state_d = LS_PEND;
            LS_PEND: begin
                if (take)         state_d = set_req ? LS_BOTH : LS_ACT;
                else if (clr_req) state_d = LS_IDLE;
            end
            LS_ACT: begin
                if (finish)     state_d = raise ? LS_PEND : LS_IDLE;
                else if (raise) state_d = LS_BOTH;
            end
            LS_BOTH: begin
                if (take)         state_d = LS_ACT;
                else if (finish)  state_d = clr_req ? LS_IDLE : LS_PEND;
                else if (clr_req) state_d = LS_ACT;
            end
            default: state_d = LS_IDLE;
        endcase
    end

    always_comb begin
        pend_o = 1'b0;
        act_o  = 1'b0;
        unique case (state_q)
            LS_IDLE: ;
            LS_PEND: pend_o = 1'b1;
            LS_ACT:  act_o  = 1'b1;
            LS_BOTH: begin pend_o = 1'b1; act_o = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int NUM_IRQ   = 96,
    parameter int PRIO_BITS = 4,
    localparam int IDW      = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]                cand,
    input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio,
    output logic                              found,
    output logic [IDW-1:0]                    win_id,
    output logic [PRIO_BITS-1:0]              win_prio
);
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand[i] && (!found || prio[i] < win_prio)) begin
                found    = 1'b1;
                win_id   = IDW'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int NUM_IRQ   = 96,
    parameter int PRIO_BITS = 4,
    localparam int IDW      = $clog2(NUM_IRQ),
    localparam int PWORDS   = NUM_IRQ / 4,
    localparam int NREG     = NUM_IRQ / 32,
    localparam int IDX_W    = $clog2(PWORDS),
    localparam int AW       = IDX_W + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IRQ-1:0]   irq_lines,
    input  logic                 bus_we,
    input  logic [AW-1:0]        bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 core_mask,
    input  logic [PRIO_BITS:0]   core_prio,
    input  logic                 core_ack,
    input  logic                 core_done,
    input  logic [IDW-1:0]       core_done_id,
    output logic                 irq_valid,
    output logic [IDW-1:0]       irq_id,
    output logic [PRIO_BITS-1:0] irq_prio
);
    logic [2:0]                        region;
    logic [IDX_W-1:0]                  idx;
    logic [NUM_IRQ-1:0]                irq_q, rise;
    logic [NUM_IRQ-1:0]                en_vec, pend_vec, act_vec;
    logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_vec;
    logic                              win_found;
    logic [IDW-1:0]                    win_id;
    logic [PRIO_BITS-1:0]              win_prio;
    logic                              take_ok;

    assign region  = bus_addr[AW-1 -: 3];
    assign idx     = bus_addr[IDX_W-1:0];
    assign rise    = irq_lines & ~irq_q;
    assign take_ok = core_ack && irq_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_lines;
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        localparam int W = i / 32;
        localparam int B = i % 32;
        localparam int K = i / 4;
        localparam int J = i % 4;
        logic                 hit_w, hit_p, en_r, sw_set, sw_clr;
        logic [PRIO_BITS-1:0] prio_r;

        assign hit_w  = bus_we && (idx == IDX_W'(W)) && bus_wdata[B];
        assign hit_p  = bus_we && (idx == IDX_W'(K)) && (region == RG_PRIO);
        assign sw_set = hit_w && (region == RG_PEND_SET);
        assign sw_clr = hit_w && (region == RG_PEND_CLR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              en_r <= 1'b0;
            else if (hit_w && region == RG_EN_SET)   en_r <= 1'b1;
            else if (hit_w && region == RG_EN_CLR)   en_r <= 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     prio_r <= '0;
            else if (hit_p) prio_r <= bus_wdata[J*8+7 -: PRIO_BITS];
        end

        assign en_vec[i]   = en_r;
        assign prio_vec[i] = prio_r;

        pic_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (rise[i] || sw_set),
            .clr_req (sw_clr),
            .take    (take_ok && irq_id == IDW'(i)),
            .finish  (core_done && core_done_id == IDW'(i)),
            .pend_o  (pend_vec[i]),
            .act_o   (act_vec[i])
        );
    end

    pic_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_arb (
        .cand     (en_vec & pend_vec),
        .prio     (prio_vec),
        .found    (win_found),
        .win_id   (win_id),
        .win_prio (win_prio)
    );

    assign irq_valid = win_found && !core_mask && ({1'b0, win_prio} < core_prio);
    assign irq_id    = win_id;
    assign irq_prio  = win_prio;

    always_comb begin
        bus_rdata = '0;
        if (region == RG_PRIO) begin
            for (int k = 0; k < PWORDS; k++)
                if (idx == IDX_W'(k))
                    for (int j = 0; j < 4; j++)
                        bus_rdata[j*8+7 -: PRIO_BITS] = prio_vec[4*k+j];
        end else begin
            for (int w = 0; w < NREG; w++) begin
                if (idx == IDX_W'(w)) begin
                    if (region == RG_EN_SET || region == RG_EN_CLR)
                        bus_rdata = en_vec[w*32 +: 32];
                    else if (region == RG_PEND_SET || region == RG_PEND_CLR)
                        bus_rdata = pend_vec[w*32 +: 32];
                    else if (region == RG_ACTIVE)
                        bus_rdata = act_vec[w*32 +: 32];
                end
            end
        end
    end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
    parameter int NUM_IRQ   = 96,
    parameter int PRIO_BITS = 4,
    localparam int IDW      = $clog2(NUM_IRQ),
    localparam int AW       = $clog2(NUM_IRQ / 4) + 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [AW-1:0]        bus_addr,
    input logic [31:0]          bus_rdata,
    input logic                 core_mask,
    input logic [PRIO_BITS:0]   core_prio,
    input logic                 core_ack,
    input logic                 core_done,
    input logic [IDW-1:0]       core_done_id,
    input logic                 irq_valid,
    input logic [IDW-1:0]       irq_id,
    input logic [PRIO_BITS-1:0] irq_prio,
    input logic [NUM_IRQ-1:0]   en_vec,
    input logic [NUM_IRQ-1:0]   pend_vec,
    input logic [NUM_IRQ-1:0]   act_vec
);
    localparam logic [7:0]  LOW_BYTE = 8'(8'hFF >> PRIO_BITS);
    localparam logic [31:0] LOW_MASK = {4{LOW_BYTE}};

    p_mask_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        core_mask |-> !irq_valid);

    p_offer_eligible_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (en_vec[irq_id] && pend_vec[irq_id]));

    p_strict_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ({1'b0, irq_prio} < core_prio));

    p_ack_activates_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ack && irq_valid) |=> act_vec[$past(irq_id)]);

    p_done_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && !(core_ack && irq_valid && irq_id == core_done_id))
        |=> !act_vec[$past(core_done_id)]);

    p_prio_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[AW-1 -: 3] == 3'd5) |-> ((bus_rdata & LOW_MASK) == 32'h0));

    p_no_offer_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_vec & pend_vec) == '0) |-> !irq_valid);
endmodule

bind pic_top pic_checker #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .core_mask    (core_mask),
    .core_prio    (core_prio),
    .core_ack     (core_ack),
    .core_done    (core_done),
    .core_done_id (core_done_id),
    .irq_valid    (irq_valid),
    .irq_id       (irq_id),
    .irq_prio     (irq_prio),
    .en_vec       (en_vec),
    .pend_vec     (pend_vec),
    .act_vec      (act_vec)
);

// File: tb/test_pic_top.sv
module test_pic_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [7:0]  wa;
        logic [31:0] wd;
        logic [7:0]  ra;
        logic [31:0] ex;
    } vec_t;

    // regions: 0x00 en set, 0x20 en clr, 0x40 pend set, 0x60 pend clr, 0x80 active, 0xA0 prio
    localparam vec_t TBL [11] = '{
        '{8'h00, 32'h0000_00F0, 8'h00, 32'h0000_00F0},  // R2 set
        '{8'h20, 32'h0000_0030, 8'h20, 32'h0000_00C0},  // R2 clear
        '{8'h00, 32'h0000_0000, 8'h00, 32'h0000_00C0},  // R2 zeros ignored
        '{8'h02, 32'h8000_0001, 8'h02, 32'h8000_0001},  // R2 top word
        '{8'h41, 32'h0000_0005, 8'h41, 32'h0000_0005},  // R3 set
        '{8'h61, 32'h0000_0004, 8'h61, 32'h0000_0001},  // R3 clear
        '{8'h61, 32'h0000_0001, 8'h41, 32'h0000_0000},  // R3 clear last
        '{8'hA0, 32'h1234_5678, 8'hA0, 32'h1030_5070},  // R5 low nibble zero
        '{8'hB7, 32'hFFFF_FFFF, 8'hB7, 32'hF0F0_F0F0},  // R5 last word
        '{8'h20, 32'hFFFF_FFFF, 8'h00, 32'h0000_0000},  // R2 clear all
        '{8'h22, 32'hFFFF_FFFF, 8'h02, 32'h0000_0000}   // R2 clear all
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] irq_lines = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_mask = 1'b0;
    logic [4:0]  core_prio = 5'd16;
    logic        core_ack = 1'b0;
    logic        core_done = 1'b0;
    logic [6:0]  core_done_id = '0;
    logic        irq_valid;
    logic [6:0]  irq_id;
    logic [3:0]  irq_prio;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_top i_pic_top (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_mask(core_mask), .core_prio(core_prio), .core_ack(core_ack),
        .core_done(core_done), .core_done_id(core_done_id),
        .irq_valid(irq_valid), .irq_id(irq_id), .irq_prio(irq_prio)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic offer(input string tag, input logic v, input logic [6:0] id);
        check({tag, " valid"}, 32'(irq_valid), 32'(v));
        if (v) check({tag, " id"}, 32'(irq_id), 32'(id));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ack();
        core_ack = 1'b1; tick(); core_ack = 1'b0;
    endtask

    task automatic done(input logic [6:0] id);
        core_done = 1'b1; core_done_id = id; tick(); core_done = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        do_reset();

        foreach (TBL[n]) begin
            string tg;
            tg = (TBL[n].ra[7:5] <= 3'd1) ? "R2" : (TBL[n].ra[7:5] == 3'd5) ? "R5" : "R3";
            wr(TBL[n].wa, TBL[n].wd);
            rd(TBL[n].ra, d);
            check($sformatf("%s table entry %0d", tg, n), d, TBL[n].ex);
        end

        // R1: reset state
        do_reset();
        offer("R1 after reset", 1'b0, 7'd0);
        rd(8'h00, d); check("R1 enable", d, 32'h0);
        rd(8'hA0, d); check("R1 prio", d, 32'h0);
        rd(8'h80, d); check("R1 active", d, 32'h0);

        // R4 / R6 / R7
        wr(8'h00, 32'h0000_0220);          // enable lines 5 and 9
        wr(8'hA1, 32'h0000_3000);          // line 5 urgency 3
        wr(8'hA2, 32'h0000_2000);          // line 9 urgency 2
        irq_lines[5] = 1'b1; tick();
        offer("R4 edge pends", 1'b1, 7'd5);
        irq_lines[10] = 1'b1; tick();
        rd(8'h40, d); check("R4 disabled line pends", d, 32'h0000_0420);
        offer("R4 disabled not offered", 1'b1, 7'd5);
        irq_lines[9] = 1'b1; tick();
        offer("R6 lower value wins", 1'b1, 7'd9);
        wr(8'hA1, 32'h0000_2000);
        offer("R6 tie lower id", 1'b1, 7'd5);
        core_prio = 5'd2; #1;
        offer("R7 equal not offered", 1'b0, 7'd0);
        core_prio = 5'd3; #1;
        offer("R7 strictly higher", 1'b1, 7'd5);

        // R8
        core_mask = 1'b1; tick();
        offer("R8 masked", 1'b0, 7'd0);
        rd(8'h40, d); check("R8 pending kept", d, 32'h0000_0620);
        core_mask = 1'b0; #1;
        offer("R8 unmasked", 1'b1, 7'd5);

        // R9
        core_prio = 5'd16;
        ack();
        rd(8'h80, d); check("R9 active", d, 32'h0000_0020);
        rd(8'h40, d); check("R9 R4 pend cleared held level", d, 32'h0000_0600);
        offer("R9 next offered", 1'b1, 7'd9);

        // R11 nesting
        core_prio = 5'd2; #1;
        offer("R11 R7 same level blocked", 1'b0, 7'd0);
        wr(8'hA2, 32'h0000_1000);
        offer("R11 more urgent offered", 1'b1, 7'd9);
        ack();
        rd(8'h80, d); check("R11 two active", d, 32'h0000_0220);
        core_prio = 5'd1;
        done(7'd9);
        rd(8'h80, d); check("R11 inner done", d, 32'h0000_0020);
        done(7'd5);
        rd(8'h80, d); check("R11 outer done", d, 32'h0000_0000);
        offer("R11 nothing offered", 1'b0, 7'd0);

        // R10
        core_prio = 5'd16;
        irq_lines[5] = 1'b0; tick();
        irq_lines[5] = 1'b1; tick();
        offer("R10 pend again", 1'b1, 7'd5);
        ack();
        irq_lines[5] = 1'b0; tick();
        irq_lines[5] = 1'b1; tick();
        rd(8'h80, d); check("R10 active", d, 32'h0000_0020);
        rd(8'h40, d); check("R10 also pending", d, 32'h0000_0420);
        done(7'd5);
        rd(8'h80, d); check("R10 active cleared", d, 32'h0000_0000);
        rd(8'h40, d); check("R10 still pending", d, 32'h0000_0420);
        offer("R10 reoffered", 1'b1, 7'd5);

        // R12: ack and new edge in one cycle
        irq_lines[5] = 1'b0; tick();
        offer("R12 still offered", 1'b1, 7'd5);
        core_ack = 1'b1; irq_lines[5] = 1'b1; tick(); core_ack = 1'b0;
        rd(8'h80, d); check("R12 active", d, 32'h0000_0020);
        rd(8'h40, d); check("R12 pending", d, 32'h0000_0420);
        done(7'd5);
        rd(8'h40, d); check("R12 pending after done", d, 32'h0000_0420);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule